// File: doc/BRIEF.md
# Run-Time Configurable Byte-Serial CRC Calculator

This block computes a cyclic redundancy check one byte at a time for a host on a small register bus. The host picks a generator polynomial and a bit order through a control register, optionally clears or seeds the 16-bit result register, and then writes message bytes one after another into a data register. Each byte is folded into the running checksum on the clock edge that accepts the write, so the next cycle's read of the result already reflects it.

Three generators are offered. One is an 8-bit code, whose value lives in the low byte of the result. The other two are 16-bit codes. In least-significant-bit-first order the engine uses the bit-reversed generator and shifts right. In most-significant-bit-first order it uses the generator as written and shifts left. A receiver that feeds a block followed by its own check bytes, in the order they are sent, finds the result back at zero when nothing was corrupted. The `ready` output shows whether a usable generator is selected. While it is low, data writes are dropped.

Top module: `crc_byte_engine`

The register map, with `wr_addr` and `rd_addr` using the same decoding:
- 0: control
- 1: data byte (write only, reads 0)
- 2: result low byte
- 3: result high byte

## Requirements
- R1: After reset the control register reads 0x00, both result bytes read 0x00, and `ready` is low.
- R2: Writing the control register with bit 7 set clears the result to 0x0000 on that edge, and bit 7 always reads back 0.
- R3: Control bits 6 to 3 always read 0, and values written to them are discarded.
- R4: Control bits 1:0 choose the generator. 01 selects x^8+x^2+x+1 (0x07), 10 selects x^16+x^15+x^2+1 (0x8005), and 11 selects x^16+x^12+x^5+1 (0x1021). With a zero start, the nine ASCII bytes "123456789" give 0xF4 for select 01 with MSB-first order, 0xBB3D for select 10 with LSB-first order, and 0x31C3 for select 11 with MSB-first order.
- R5: Control bit 2 sets the bit order. At 0 (LSB-first) the engine uses the reflected generator and takes data bit 0 first; select 11 over "123456789" gives 0x2189. At 1 (MSB-first) it takes data bit 7 first.
- R6: A data write updates the result on its own clock edge, so a read of the result in the following cycle returns the new value.
- R7: With select 00, `ready` is low and data writes leave the result unchanged. `ready` is high for any other select.
- R8: With select 01, each data write leaves the result high byte at 0x00 and the 8-bit checksum in the low byte, even when the high byte held a nonzero value before.
- R9: Feeding a block's checksum bytes after the block leaves the result at 0x0000. For LSB-first order the low byte is fed first, for MSB-first order the high byte is fed first, and for the 8-bit code only the low byte is fed.
- R10: Writing address 2 or 3 loads the low or high result byte directly, and later data bytes continue from that seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| ready | output | 1 | High when a valid generator is selected |

## Verification
The block has no parameters: the widths, the address map and the three generators are fixed. A single build therefore reaches every combination of generator and bit order, and the bench switches among them at run time. The bench checks the published check values for "123456789", the zero residue after each block's own checksum is appended, and a pseudo-random byte stream in all six modes. It also covers seeding, the select-00 hold, and the forced-zero high byte of the 8-bit code.

// File: rtl/crc_byte_engine.sv
module crc_byte_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       ready
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_LO   = 2'd2;
  localparam logic [1:0] A_HI   = 2'd3;

  logic        msb_first;
  logic [1:0]  poly_sel;
  logic [15:0] crc_q;

  function automatic logic [15:0] fold_byte(input logic [15:0] c, input logic [7:0] d,
                                            input logic msb, input logic [1:0] sel);
    logic [15:0] r;
    logic [15:0] g;
    r = c;
    case ({msb, sel})
      3'b101:  g = 16'h0007;
      3'b110:  g = 16'h8005;
      3'b111:  g = 16'h1021;
      3'b001:  g = 16'h00E0;
      3'b010:  g = 16'hA001;
      default: g = 16'h8408;
    endcase
    if (sel == 2'b01) begin
      r[15:8] = 8'h00;
      r[7:0]  = r[7:0] ^ d;
      for (int i = 0; i < 8; i++) begin
        if (msb) r[7:0] = r[7] ? ({r[6:0], 1'b0} ^ g[7:0]) : {r[6:0], 1'b0};
        else     r[7:0] = r[0] ? ((r[7:0] >> 1) ^ g[7:0]) : (r[7:0] >> 1);
      end
    end else if (msb) begin
      r = r ^ {d, 8'h00};
      for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ g) : (r << 1);
    end else begin
      r = r ^ {8'h00, d};
      for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ g) : (r >> 1);
    end
    return r;
  endfunction

  assign ready = (poly_sel != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_first <= 1'b0;
      poly_sel  <= 2'b00;
      crc_q     <= 16'h0000;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          msb_first <= wr_data[2];
          poly_sel  <= wr_data[1:0];
          if (wr_data[7]) crc_q <= 16'h0000;
        end
        A_DATA: if (ready) crc_q <= fold_byte(crc_q, wr_data, msb_first, poly_sel);
        A_LO:   crc_q[7:0]  <= wr_data;
        default: crc_q[15:8] <= wr_data;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {5'b00000, msb_first, poly_sel};
      A_DATA:  rd_data = 8'h00;
      A_LO:    rd_data = crc_q[7:0];
      default: rd_data = crc_q[15:8];
    endcase
  end
endmodule

module crc_byte_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic [7:0]  wr_data,
  input logic [1:0]  rd_addr,
  input logic [7:0]  rd_data,
  input logic        ready,
  input logic [1:0]  poly_sel,
  input logic [15:0] crc_q
);
  a_r2_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && wr_data[7]) |=> (crc_q == 16'h0000));

  a_r3_reserved_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd0) |-> (rd_data[7:3] == 5'b00000));

  a_r7_hold_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1 && !ready) |=> $stable(crc_q));

  a_r8_high_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1 && poly_sel == 2'b01) |=> (crc_q[15:8] == 8'h00));

  a_r10_seed_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2) |=> (crc_q[7:0] == $past(wr_data)));

  a_r10_seed_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3) |=> (crc_q[15:8] == $past(wr_data)));
endmodule

bind crc_byte_engine crc_byte_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready), .poly_sel(poly_sel), .crc_q(crc_q)
);

// File: tb/test_crc_byte_engine.sv
module test_crc_byte_engine;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       ready;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [1:0] a;
    logic [7:0] v;
    string      tag;
  } item_t;
  item_t q[$];

  logic        m_msb = 1'b0;
  logic [1:0]  m_sel = 2'b00;
  logic [15:0] m_crc = 16'h0000;

  crc_byte_engine i_crc_byte_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [15:0] model(logic [15:0] c, logic [7:0] d, logic msb, logic [1:0] s);
    int w;
    logic [15:0] p;
    logic [15:0] rp;
    logic fb;
    w = (s == 2'b01) ? 8 : 16;
    p = (s == 2'b01) ? 16'h0007 : (s == 2'b10) ? 16'h8005 : 16'h1021;
    rp = 16'h0000;
    for (int i = 0; i < w; i++) rp[w-1-i] = p[i];
    if (w == 8) c[15:8] = 8'h00;
    for (int k = 0; k < 8; k++) begin
      if (msb) begin
        fb = c[w-1] ^ d[7-k];
        c = c << 1;
        if (w == 8) c[15:8] = 8'h00;
        if (fb) c = c ^ p;
      end else begin
        fb = c[0] ^ d[k];
        c = c >> 1;
        if (fb) c = c ^ rp;
      end
    end
    return c;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      2'd0: begin
        if (d[7]) m_crc = 16'h0000;
        m_msb = d[2]; m_sel = d[1:0];
      end
      2'd1: if (m_sel != 2'b00) m_crc = model(m_crc, d, m_msb, m_sel);
      2'd2: m_crc[7:0] = d;
      default: m_crc[15:8] = d;
    endcase
  endtask

  task automatic expect_rd(input logic [1:0] a, input logic [7:0] v, input string tag);
    item_t it;
    it.a = a; it.v = v; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic expect_res(input logic [15:0] v, input string tag);
    expect_rd(2'd2, v[7:0], tag);
    expect_rd(2'd3, v[15:8], tag);
  endtask

  task automatic chk_ready(input logic exp, input string tag);
    total++;
    if (ready !== exp) begin
      bad++;
      $display("FAIL %s ready actual=%b expected=%b", tag, ready, exp);
    end
  endtask

  task automatic feed_vector;
    for (int i = 0; i < 9; i++) wr(2'd1, 8'h31 + 8'(i));
  endtask

  task automatic residue(input string tag);
    logic [15:0] c;
    c = m_crc;
    if (m_sel == 2'b01) wr(2'd1, c[7:0]);
    else if (m_msb) begin wr(2'd1, c[15:8]); wr(2'd1, c[7:0]); end
    else begin wr(2'd1, c[7:0]); wr(2'd1, c[15:8]); end
    expect_res(16'h0000, tag);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q[0];
        rd_addr = it.a;
        #1;
        total++;
        if (rd_data !== it.v) begin
          bad++;
          $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.a, rd_data, it.v);
        end
        void'(q.pop_front());
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    logic [7:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_rd(2'd0, 8'h00, "R1 ctrl");
    expect_res(16'h0000, "R1 result");
    chk_ready(1'b0, "R1");

    // R10 seed, R7 hold with select 00
    wr(2'd2, 8'h34); wr(2'd3, 8'h12);
    expect_res(16'h1234, "R10 seed");
    wr(2'd1, 8'h55); wr(2'd1, 8'hAA);
    expect_res(16'h1234, "R7 hold");
    chk_ready(1'b0, "R7 sel00");

    // R2 clear, R3 reserved bits; LSB-first CCITT (R5)
    wr(2'd0, 8'hFB);
    expect_rd(2'd0, 8'h03, "R3 R2 ctrl readback");
    expect_res(16'h0000, "R2 clear");
    chk_ready(1'b1, "R7 sel11");
    wr(2'd1, 8'h31);
    expect_res(model(16'h0000, 8'h31, 1'b0, 2'b11), "R6 next cycle");
    wr(2'd0, 8'h83);
    feed_vector();
    expect_res(16'h2189, "R5 lsb ccitt");
    residue("R9 lsb ccitt");

    // MSB-first CCITT (R4)
    wr(2'd0, 8'h87);
    feed_vector();
    expect_res(16'h31C3, "R4 msb ccitt");
    residue("R9 msb ccitt");

    // LSB-first 0x8005 (R4)
    wr(2'd0, 8'h82);
    feed_vector();
    expect_res(16'hBB3D, "R4 lsb 8005");
    residue("R9 lsb 8005");

    // 8-bit code with nonzero high seed (R8)
    wr(2'd0, 8'h85);
    wr(2'd3, 8'hAB);
    expect_res(16'hAB00, "R10 high seed");
    feed_vector();
    expect_res(16'h00F4, "R8 R4 crc8");
    residue("R9 crc8");

    // 8-bit LSB-first
    wr(2'd0, 8'h81);
    feed_vector();
    expect_res(m_crc, "R5 R8 crc8 lsb");
    residue("R9 crc8 lsb");

    // R10 seed continues, then pseudo-random stream in every mode
    lfsr = 8'h5A;
    for (int mode = 0; mode < 6; mode++) begin
      wr(2'd0, 8'h80 | 8'((mode / 3) << 2) | 8'((mode % 3) + 1));
      wr(2'd2, lfsr); wr(2'd3, ~lfsr);
      for (int n = 0; n < 20; n++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        wr(2'd1, lfsr);
      end
      expect_res(m_crc, "R4 R5 R10 stream");
    end

    // R7: switching to 00 freezes the value
    wr(2'd0, 8'h04);
    wr(2'd1, 8'h77);
    expect_res(m_crc, "R7 hold after use");
    expect_rd(2'd1, 8'h00, "R3 data reads zero");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule